// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block moves a processor subsystem between full operation and four low-power levels: doze, nap, sleep and deep sleep. Each deeper level adds one more core control on top of the previous one. Doze holds the core halted. Nap also stops it. Sleep also turns the timebase off. Deep sleep also removes core power. Software asks for a level with a one-cycle request and a 2-bit target code. The controller then raises the controls one at a time. It waits for the core to acknowledge the halt before it stops the core. It waits for the core to acknowledge the stop before it touches the timebase or the power.

Five wake-up sources feed the block: a LAN magic packet, a LAN user pattern, USB activity, a GPIO event and an internal timer. A mask gates each source, and the enabled sources are merged into one registered wake interrupt. The wake interrupt undoes the controls in reverse order. Power returns first, followed by a fixed power-good wait. The timebase is then re-enabled, then stop is released, then halt is released. A wake that arrives while an entry is still in progress cancels the entry and brings the subsystem back to full operation.

A 3-bit status code reports the level the subsystem currently rests in. A one-cycle pulse marks each change of that code.

Top module: `lp_state_ctrl`

## Requirements
- R1: After reset the outputs are haltReq=0, stopReq=0, tbEn=1, pwrOff=0, wakeIrq=0, stateCode=0 and transPulse=0.
- R2: stateCode uses 0=full-on, 1=doze, 2=nap, 3=sleep, 4=deep sleep. lpTarget selects the level: 0=doze, 1=nap, 2=sleep, 3=deep sleep. transPulse is high for exactly the one cycle in which stateCode takes a new value.
- R3: A request raises haltReq on the next cycle. With target doze, the first cycle after haltAck is sampled high shows stateCode=1 with haltReq=1, stopReq=0, tbEn=1 and pwrOff=0.
- R4: stopReq stays low until haltAck has been sampled high, and rises on the next cycle. Nap rests with haltReq=1, stopReq=1, tbEn=1 and pwrOff=0.
- R5: tbEn stays high until stopAck has been sampled high. Sleep rests with haltReq=1, stopReq=1, tbEn=0 and pwrOff=0.
- R6: pwrOff stays low until stopAck has been sampled high. Deep sleep rests with haltReq=1, stopReq=1, tbEn=0 and pwrOff=1.
- R7: wakeIrq is high in the cycle after any wakeSrc bit whose wakeEn bit is set is high. The bits are 0=LAN magic packet, 1=LAN user pattern, 2=USB, 3=GPIO and 4=timer. A source whose enable bit is clear leaves wakeIrq and the resting state unchanged.
- R8: A wake while resting undoes the controls in reverse order. pwrOff falls first, tbEn rises PG_CYCLES (16) cycles later, stopReq falls one cycle after that, and haltReq falls one cycle after that. stateCode returns to 0 in the same cycle that haltReq falls.
- R9: A wake that arrives before the entry acknowledges complete cancels the entry. All controls are released, stateCode stays 0 and transPulse does not fire.
- R10: lpReq is ignored unless the controller is at full-on and idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpReq | input | 1 | One-cycle low-power request |
| lpTarget | input | 2 | Target level code for lpReq |
| wakeSrc | input | NUM_WAKE (5) | Wake-up event inputs |
| wakeEn | input | NUM_WAKE (5) | Per-source wake enable mask |
| haltAck | input | 1 | Core reports it is halted |
| stopAck | input | 1 | Core reports it is stopped |
| haltReq | output | 1 | Hold the core halted |
| stopReq | output | 1 | Stop the core |
| tbEn | output | 1 | Timebase enable |
| pwrOff | output | 1 | Remove core power (deep sleep) |
| wakeIrq | output | 1 | Merged, masked wake interrupt |
| stateCode | output | 3 | Current resting level |
| transPulse | output | 1 | One-cycle pulse on each change of stateCode |

## Verification
The case hardest to reach is a wake that lands in the middle of an entry, while the controller is still waiting for the halt or stop acknowledge. The stimulus produces it by starting a request, withholding the acknowledge, and injecting a wake event during the wait. It then confirms that the controls unwind without any status pulse. Randomized rounds vary the target level, the acknowledge delays and the waking source. In each round a masked decoy source is held active first, to show it does not end the stay. The bench then times the gaps between the release edges on exit.

// File: rtl/lp_state_pkg.sv
package lp_state_pkg;

  typedef enum logic [2:0] {
    ST_FULL  = 3'd0,
    ST_DOZE  = 3'd1,
    ST_NAP   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_DEEP  = 3'd4
  } lpState_e;

  typedef enum logic [1:0] {
    TGT_DOZE  = 2'd0,
    TGT_NAP   = 2'd1,
    TGT_SLEEP = 2'd2,
    TGT_DEEP  = 2'd3
  } lpTarget_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic     setHalt;
    logic     clrHalt;
    logic     setStop;
    logic     clrStop;
    logic     tbOff;
    logic     tbOn;
    logic     pwrDown;
    logic     pwrUp;
    logic     cntLoad;
    logic     loadTgt;
    logic     commit;
    lpState_e commitCode;
  } lpStrobe_t;

  function automatic lpState_e residentOf(lpTarget_e t);
    case (t)
      TGT_DOZE:  return ST_DOZE;
      TGT_NAP:   return ST_NAP;
      TGT_SLEEP: return ST_SLEEP;
      default:   return ST_DEEP;
    endcase
  endfunction

endpackage

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_state_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lpReq,
  input  logic      haltAck,
  input  logic      stopAck,
  input  logic      wakeIrq,
  input  logic      pgDone,
  input  lpTarget_e tgtQ,
  output lpStrobe_t strb
);

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ENT_HALT,
    SEQ_ENT_STOP,
    SEQ_RESIDE,
    SEQ_EXIT_PWR,
    SEQ_EXIT_STOP,
    SEQ_EXIT_HALT
  } seq_e;

  seq_e cur, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) cur <= SEQ_IDLE;
    else       cur <= nxt;
  end

  always_comb begin
    strb = '0;
    strb.commitCode = ST_FULL;
    nxt = cur;
    case (cur)
      SEQ_IDLE: begin
        if (lpReq) begin
          strb.loadTgt = 1'b1;
          strb.setHalt = 1'b1;
          nxt = SEQ_ENT_HALT;
        end
      end
      SEQ_ENT_HALT: begin
        if (wakeIrq) begin
          strb.clrHalt = 1'b1;
          strb.commit = 1'b1;
          strb.commitCode = ST_FULL;
          nxt = SEQ_IDLE;
        end else if (haltAck) begin
          if (tgtQ == TGT_DOZE) begin
            strb.commit = 1'b1;
            strb.commitCode = ST_DOZE;
            nxt = SEQ_RESIDE;
          end else begin
            strb.setStop = 1'b1;
            nxt = SEQ_ENT_STOP;
          end
        end
      end
      SEQ_ENT_STOP: begin
        if (wakeIrq) begin
          strb.clrStop = 1'b1;
          nxt = SEQ_EXIT_HALT;
        end else if (stopAck) begin
          strb.commit = 1'b1;
          strb.commitCode = residentOf(tgtQ);
          strb.tbOff = (tgtQ == TGT_SLEEP) || (tgtQ == TGT_DEEP);
          strb.pwrDown = (tgtQ == TGT_DEEP);
          nxt = SEQ_RESIDE;
        end
      end
      SEQ_RESIDE: begin
        if (wakeIrq) begin
          case (tgtQ)
            TGT_DEEP: begin
              strb.pwrUp = 1'b1;
              strb.cntLoad = 1'b1;
              nxt = SEQ_EXIT_PWR;
            end
            TGT_SLEEP: begin
              strb.tbOn = 1'b1;
              nxt = SEQ_EXIT_STOP;
            end
            TGT_NAP: begin
              strb.clrStop = 1'b1;
              nxt = SEQ_EXIT_HALT;
            end
            default: begin
              strb.clrHalt = 1'b1;
              strb.commit = 1'b1;
              strb.commitCode = ST_FULL;
              nxt = SEQ_IDLE;
            end
          endcase
        end
      end
      SEQ_EXIT_PWR: begin
        if (pgDone) begin
          strb.tbOn = 1'b1;
          nxt = SEQ_EXIT_STOP;
        end
      end
      SEQ_EXIT_STOP: begin
        strb.clrStop = 1'b1;
        nxt = SEQ_EXIT_HALT;
      end
      SEQ_EXIT_HALT: begin
        strb.clrHalt = 1'b1;
        strb.commit = 1'b1;
        strb.commitCode = ST_FULL;
        nxt = SEQ_IDLE;
      end
      default: nxt = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_state_pkg::*;
#(
  parameter int NUM_WAKE  = 5,
  parameter int PG_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  lpStrobe_t           strb,
  input  logic [1:0]          lpTarget,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic [NUM_WAKE-1:0] wakeEn,
  output logic                haltReq,
  output logic                stopReq,
  output logic                tbEn,
  output logic                pwrOff,
  output logic                wakeIrq,
  output logic [2:0]          stateCode,
  output logic                transPulse,
  output lpTarget_e           tgtQ,
  output logic                pgDone
);

  localparam int CW = (PG_CYCLES < 2) ? 1 : $clog2(PG_CYCLES + 1);
  localparam logic [CW-1:0] PG_LOAD = CW'(PG_CYCLES - 1);

  logic [NUM_WAKE-1:0] wakeGated;
  logic [CW-1:0]       pgCnt;
  lpState_e            stateR;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wakeGate
    assign wakeGated[i] = wakeSrc[i] & wakeEn[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) wakeIrq <= 1'b0;
    else       wakeIrq <= |wakeGated;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReq <= 1'b0;
      stopReq <= 1'b0;
      tbEn    <= 1'b1;
      pwrOff  <= 1'b0;
    end else begin
      if (strb.setHalt)      haltReq <= 1'b1;
      else if (strb.clrHalt) haltReq <= 1'b0;
      if (strb.setStop)      stopReq <= 1'b1;
      else if (strb.clrStop) stopReq <= 1'b0;
      if (strb.tbOff)        tbEn <= 1'b0;
      else if (strb.tbOn)    tbEn <= 1'b1;
      if (strb.pwrDown)      pwrOff <= 1'b1;
      else if (strb.pwrUp)   pwrOff <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tgtQ <= TGT_DOZE;
    else if (strb.loadTgt) tgtQ <= lpTarget_e'(lpTarget);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pgCnt <= '0;
    else if (strb.cntLoad)   pgCnt <= PG_LOAD;
    else if (pgCnt != '0)    pgCnt <= pgCnt - 1'b1;
  end

  assign pgDone = (pgCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR     <= ST_FULL;
      transPulse <= 1'b0;
    end else begin
      transPulse <= strb.commit && (strb.commitCode != stateR);
      if (strb.commit) stateR <= strb.commitCode;
    end
  end

  assign stateCode = stateR;

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_state_pkg::*;
#(
  parameter int NUM_WAKE  = 5,
  parameter int PG_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lpReq,
  input  logic [1:0]          lpTarget,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic                haltAck,
  input  logic                stopAck,
  output logic                haltReq,
  output logic                stopReq,
  output logic                tbEn,
  output logic                pwrOff,
  output logic                wakeIrq,
  output logic [2:0]          stateCode,
  output logic                transPulse
);

  lpStrobe_t strb;
  lpTarget_e tgtQ;
  logic      pgDone;

  lp_seq_ctrl u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .lpReq   (lpReq),
    .haltAck (haltAck),
    .stopAck (stopAck),
    .wakeIrq (wakeIrq),
    .pgDone  (pgDone),
    .tgtQ    (tgtQ),
    .strb    (strb)
  );

  lp_datapath #(
    .NUM_WAKE  (NUM_WAKE),
    .PG_CYCLES (PG_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lpTarget   (lpTarget),
    .wakeSrc    (wakeSrc),
    .wakeEn     (wakeEn),
    .haltReq    (haltReq),
    .stopReq    (stopReq),
    .tbEn       (tbEn),
    .pwrOff     (pwrOff),
    .wakeIrq    (wakeIrq),
    .stateCode  (stateCode),
    .transPulse (transPulse),
    .tgtQ       (tgtQ),
    .pgDone     (pgDone)
  );

endmodule

// File: rtl/lp_state_chk.sv
module lp_state_chk (
  input logic       clk,
  input logic       rstN,
  input logic       haltAck,
  input logic       stopAck,
  input logic       haltReq,
  input logic       stopReq,
  input logic       tbEn,
  input logic       pwrOff,
  input logic [2:0] stateCode,
  input logic       transPulse
);

  AST_STOP_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> haltReq); // R4

  AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopReq) |-> $past(haltAck)); // R4

  AST_TB_OFF_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tbEn) |-> $past(stopAck)); // R5

  AST_TB_OFF_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !tbEn |-> stopReq); // R5

  AST_OFF_NEEDS_TB_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pwrOff |-> !tbEn); // R6

  AST_POWER_BEFORE_TB: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOff) |-> !tbEn); // R8

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    transPulse |-> (stateCode != $past(stateCode))); // R2

  AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> transPulse); // R2

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd4); // R2

endmodule

bind lp_state_ctrl lp_state_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .haltAck    (haltAck),
  .stopAck    (stopAck),
  .haltReq    (haltReq),
  .stopReq    (stopReq),
  .tbEn       (tbEn),
  .pwrOff     (pwrOff),
  .stateCode  (stateCode),
  .transPulse (transPulse)
);

// File: tb/lp_state_ctrl_test.sv
module lp_state_ctrl_test;

  localparam int NW = 5;
  localparam int PG = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lpReq = 1'b0;
  logic [1:0]    lpTarget = 2'd0;
  logic [NW-1:0] wakeSrc = '0;
  logic [NW-1:0] wakeEn = '0;
  logic          haltAck = 1'b0;
  logic          stopAck = 1'b0;
  logic          haltReq, stopReq, tbEn, pwrOff, wakeIrq, transPulse;
  logic [2:0]    stateCode;

  always #4 clk = ~clk;

  lp_state_ctrl #(.NUM_WAKE(NW), .PG_CYCLES(PG)) uut (
    .clk(clk), .rstN(rstN), .lpReq(lpReq), .lpTarget(lpTarget),
    .wakeSrc(wakeSrc), .wakeEn(wakeEn), .haltAck(haltAck), .stopAck(stopAck),
    .haltReq(haltReq), .stopReq(stopReq), .tbEn(tbEn), .pwrOff(pwrOff),
    .wakeIrq(wakeIrq), .stateCode(stateCode), .transPulse(transPulse)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int pulses = 0;
  int tOffFall, tTbRise, tStopFall, tHaltFall;
  logic pOff = 1'b0, pTb = 1'b1, pStop = 1'b0, pHalt = 1'b0;

  // edge recorder, reads outputs settled from the previous cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (transPulse) pulses <= pulses + 1;
      if (pOff && !pwrOff)   tOffFall  <= cyc;
      if (!pTb && tbEn)      tTbRise   <= cyc;
      if (pStop && !stopReq) tStopFall <= cyc;
      if (pHalt && !haltReq) tHaltFall <= cyc;
    end
    pOff <= pwrOff; pTb <= tbEn; pStop <= stopReq; pHalt <= haltReq;
  end

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // {halt, stop, tb, off} expected for each resting code
  function automatic int expCtl(int st);
    case (st)
      0: return 4'b0010;
      1: return 4'b1010;
      2: return 4'b1110;
      3: return 4'b1100;
      default: return 4'b1101;
    endcase
  endfunction

  function automatic string reqOf(int tgt);
    case (tgt)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int ctlNow();
    return int'({haltReq, stopReq, tbEn, pwrOff});
  endfunction

  task automatic enterState(int tgt, int hd, int sd);
    @(negedge clk); lpReq = 1'b1; lpTarget = 2'(tgt);
    @(negedge clk); lpReq = 1'b0;
    chk("R3", "halt raised", int'(haltReq), 1);
    chk("R4", "stop waits for halt ack", int'(stopReq), 0);
    for (int i = 0; i < hd; i++) begin
      @(negedge clk);
      chk("R4", "no stop before halt ack", int'(stopReq), 0);
    end
    haltAck = 1'b1;
    @(negedge clk);
    if (tgt != 0) begin
      chk("R4", "stop after halt ack", int'(stopReq), 1);
      for (int i = 0; i < sd; i++) begin
        @(negedge clk);
        chk("R5", "tb on before stop ack", int'(tbEn), 1);
        chk("R6", "power on before stop ack", int'(pwrOff), 0);
      end
      stopAck = 1'b1;
      @(negedge clk);
    end
    chk("R2", "resting code", int'(stateCode), tgt + 1);
    chk("R2", "entry pulse", int'(transPulse), 1);
    chk(reqOf(tgt), "resting controls", ctlNow(), expCtl(tgt + 1));
    @(negedge clk);
    chk("R2", "pulse lasts one cycle", int'(transPulse), 0);
  endtask

  task automatic maskedPoke(int b, int st);
    wakeEn[b] = 1'b0;
    wakeSrc[b] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7", "masked source no irq", int'(wakeIrq), 0);
    end
    wakeSrc[b] = 1'b0;
    chk("R7", "masked source keeps state", int'(stateCode), st);
    chk("R7", "masked source keeps controls", ctlNow(), expCtl(st));
  endtask

  task automatic wakeUp(int b, int tgt);
    int guard;
    tOffFall = -1; tTbRise = -1; tStopFall = -1; tHaltFall = -1;
    wakeEn[b] = 1'b1;
    wakeSrc[b] = 1'b1;
    @(negedge clk); wakeSrc[b] = 1'b0;
    chk("R7", "wake irq raised", int'(wakeIrq), 1);
    guard = 0;
    while (stateCode != 3'd0 && guard < 64) begin
      @(negedge clk); guard++;
    end
    chk("R8", "back to full-on", int'(stateCode), 0);
    chk("R2", "exit pulse", int'(transPulse), 1);
    chk("R8", "controls released", ctlNow(), expCtl(0));
    haltAck = 1'b0; stopAck = 1'b0;
    @(negedge clk);
    if (tgt == 3) chk("R8", "power-good gap", tTbRise - tOffFall, PG);
    if (tgt >= 2) chk("R8", "stop after tb", tStopFall - tTbRise, 1);
    if (tgt >= 1) chk("R8", "halt after stop", tHaltFall - tStopFall, 1);
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h1ce5eed));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset controls", ctlNow(), 4'b0010);
    chk("R1", "reset wake irq", int'(wakeIrq), 0);
    chk("R1", "reset state", int'(stateCode), 0);
    chk("R1", "reset pulse", int'(transPulse), 0);

    // directed: each level, immediate acknowledges
    for (int t = 0; t < 4; t++) begin
      wakeEn = '1;
      enterState(t, 0, 0);
      wakeUp(t, t);
    end

    // R10: request ignored while resting in doze
    wakeEn = '1;
    enterState(0, 1, 0);
    @(negedge clk); lpReq = 1'b1; lpTarget = 2'd3;
    @(negedge clk); lpReq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "request ignored state", int'(stateCode), 1);
    chk("R10", "request ignored controls", ctlNow(), expCtl(1));
    wakeUp(4, 0);

    // R9: abort while waiting for halt acknowledge
    wakeEn = '1;
    base = pulses;
    @(negedge clk); lpReq = 1'b1; lpTarget = 2'd3;
    @(negedge clk); lpReq = 1'b0;
    wakeSrc[2] = 1'b1;
    @(negedge clk); wakeSrc[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "abort in halt phase controls", ctlNow(), expCtl(0));
    chk("R9", "abort in halt phase state", int'(stateCode), 0);
    @(negedge clk);
    chk("R9", "abort in halt phase no pulse", pulses - base, 0);

    // R9: abort while waiting for stop acknowledge
    base = pulses;
    @(negedge clk); lpReq = 1'b1; lpTarget = 2'd2;
    @(negedge clk); lpReq = 1'b0; haltAck = 1'b1;
    @(negedge clk);
    chk("R9", "stop raised before abort", int'(stopReq), 1);
    wakeSrc[3] = 1'b1;
    @(negedge clk); wakeSrc[3] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "abort in stop phase controls", ctlNow(), expCtl(0));
    chk("R9", "abort in stop phase state", int'(stateCode), 0);
    @(negedge clk);
    chk("R9", "abort in stop phase no pulse", pulses - base, 0);
    haltAck = 1'b0;
    repeat (2) @(negedge clk);

    // random rounds with a masked decoy source
    for (int r = 0; r < 24; r++) begin
      int tgt, hd, sd, b, d;
      tgt = int'($urandom % 4);
      hd  = int'($urandom % 4);
      sd  = int'($urandom % 4);
      b   = int'($urandom % NW);
      d   = (b + 1 + int'($urandom % (NW - 1))) % NW;
      wakeEn = '1;
      wakeEn[d] = 1'b0;
      enterState(tgt, hd, sd);
      maskedPoke(d, tgt + 1);
      wakeUp(b, tgt);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule